// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block sits on the processor side of the interrupt path. It decides when a pending request is taken and where the program counter goes next. The core reports each completed instruction with a pulse and gives the return program counter with it. Two groups of level-sensitive request lines come in: external sources and internal sources. When the global enable flag is set and a request is pending, the sequencer acts at the instruction boundary. It raises a one-cycle redirect that carries the handler address. In the same cycle it issues a save strobe with the program counter to push, and a one-hot acknowledge to the chosen source. It also clears the global enable flag.

Every source owns a fixed vector slot. External sources take the low slots and internal sources take the slots directly above them. The handler address is the slot number times a parameterised step, plus a base address. When several sources are pending, the lowest slot wins. Software can set or clear the enable flag through two strobes. A return-from-handler strobe sets the flag again so that the interrupted program resumes with interrupts enabled.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the enable flag `ie_o` is 0, and `redirect_o`, `save_o` and every acknowledge bit are 0.
- R2: An entry is accepted only in a cycle where `instr_done_i` is 1, `ie_o` is 1 and at least one request is pending. `redirect_o` is then 1 for exactly the following cycle. No redirect occurs while `instr_done_i` is 0.
- R3: In the redirect cycle `save_o` is 1, and `save_pc_o` equals the `pc_i` value that was present in the accepting cycle.
- R4: The enable flag reads 0 from the redirect cycle onward. No further entry is accepted until the flag is set again, even if requests and `instr_done_i` stay high.
- R5: External source i (bit i of `ext_req_i`) uses slot i. Internal source j (bit j of `int_req_i`) uses slot N_EXT+j. `target_o` equals VEC_BASE + slot × VEC_STEP. With the defaults, the external sources map to 0x000–0x002 and the internal sources map to 0x003–0x00C.
- R6: When several sources are pending at acceptance, the one with the lowest slot number is chosen. Any external source therefore beats any internal one.
- R7: In the redirect cycle exactly one acknowledge bit is 1, namely the chosen source's bit in `ack_ext_o` or `ack_int_o`. Outside redirect cycles all acknowledge bits are 0.
- R8: A pulse on `reti_i` or `ie_set_i` makes `ie_o` read 1 on the next cycle. A pulse on `ie_clr_i` alone makes it read 0. When a set and a clear arrive in the same cycle, the set wins. An accepted entry overrides all three.
- R9: While `ie_o` is 0, the request lines have no effect: there is no redirect, no save and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_done_i | input | 1 | Current instruction has completed this cycle |
| pc_i | input | PC_W | Return program counter at this boundary |
| ext_req_i | input | N_EXT | External request lines, level-sensitive |
| int_req_i | input | N_INT | Internal request lines, level-sensitive |
| reti_i | input | 1 | Return-from-handler strobe |
| ie_set_i | input | 1 | Software set of the enable flag |
| ie_clr_i | input | 1 | Software clear of the enable flag |
| redirect_o | output | 1 | Program counter redirect, one cycle |
| target_o | output | PC_W | Handler address for the redirect |
| save_o | output | 1 | Push strobe for the return program counter |
| save_pc_o | output | PC_W | Program counter value to push |
| ack_ext_o | output | N_EXT | One-hot acknowledge to an external source |
| ack_int_o | output | N_INT | One-hot acknowledge to an internal source |
| ie_o | output | 1 | Global interrupt enable flag |

## Verification
The bench builds the block with its defaults: 3 external sources, 10 internal sources, a vector step of 1, base 0 and a 12-bit program counter. With only 13 slots, every single source can be taken and every ordered pair of sources can be raised together. This covers the full address map and the whole priority order, including each boundary between the external and internal groups. Separate sequences cover held requests after an entry, requests with enable off, boundary-less cycles, and each combination of the enable strobes.

// File: rtl/irq_pkg.sv
package irq_pkg;

   // Index width for a population of n items, never below one bit.
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   // Operation applied to the enable flag in a given cycle.
   typedef enum logic [1:0] {
      IE_KEEP  = 2'd0,
      IE_RAISE = 2'd1,
      IE_DROP  = 2'd2
   } ie_op_e;

endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int unsigned N  = 13,
   localparam int unsigned IW = irq_pkg::idx_bits(N)
) (
   input  logic [N-1:0]  req_i,
   output logic          any_o,
   output logic [N-1:0]  grant_o,
   output logic [IW-1:0] idx_o
);

   if (N < 1) begin : g_bad_n
      $error("irq_pick: N must be at least 1");
   end

   // below[i] is set when some request with index lower than i is pending
   logic [N:0] below;
   assign below[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign below[i+1]  = below[i] | req_i[i];
      assign grant_o[i]  = req_i[i] & ~below[i];
   end

   assign any_o = below[N];

   always_comb begin
      idx_o = '0;
      for (int k = 0; k < N; k++) begin
         if (grant_o[k]) idx_o = idx_o | IW'(k);
      end
   end

   always_comb begin
      if (any_o) assert_grant_onehot_R6: assert ($onehot(grant_o));
   end

endmodule

// File: rtl/irq_vec_map.sv
module irq_vec_map #(
   parameter int unsigned IW        = 4,
   parameter int unsigned PC_W      = 12,
   parameter int unsigned VEC_STEP  = 1,
   parameter int unsigned VEC_BASE  = 0,
   parameter int unsigned N_SLOTS   = 13
) (
   input  logic [IW-1:0]   slot_i,
   output logic [PC_W-1:0] addr_o
);

   localparam bit POW2 = (VEC_STEP != 0) && ((VEC_STEP & (VEC_STEP - 1)) == 0);
   localparam int unsigned SH = (VEC_STEP < 2) ? 0 : $clog2(VEC_STEP);
   localparam int unsigned LIMIT = VEC_BASE + N_SLOTS * VEC_STEP;

   if (VEC_STEP == 0) begin : g_bad_step
      $error("irq_vec_map: VEC_STEP must be nonzero");
   end
   if (IW > PC_W) begin : g_bad_width
      $error("irq_vec_map: slot index wider than program counter");
   end

   logic [PC_W-1:0] offset;

   if (POW2) begin : g_shift
      assign offset = PC_W'(slot_i) << SH;
   end else begin : g_mult
      assign offset = PC_W'(slot_i) * PC_W'(VEC_STEP);
   end

   assign addr_o = PC_W'(VEC_BASE) + offset;

   always_comb begin
      if (slot_i < IW'(N_SLOTS))
         assert_addr_in_table_R5: assert ({1'b0, addr_o} < (PC_W+1)'(LIMIT));
   end

endmodule

// File: rtl/irq_ie_ctl.sv
module irq_ie_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic entry_i,
   input  logic reti_i,
   input  logic set_i,
   input  logic clr_i,
   output logic ie_o
);
   import irq_pkg::*;

   ie_op_e op;
   logic   ie_q;

   always_comb begin
      if (entry_i)               op = IE_DROP;
      else if (reti_i || set_i)  op = IE_RAISE;
      else if (clr_i)            op = IE_DROP;
      else                       op = IE_KEEP;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_q <= 1'b0;
      end else begin
         case (op)
            IE_RAISE: ie_q <= 1'b1;
            IE_DROP:  ie_q <= 1'b0;
            default:  ie_q <= ie_q;
         endcase
      end
   end

   assign ie_o = ie_q;

   assert_return_enables_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_i && !entry_i) |=> ie_o);

   assert_entry_disables_R4: assert property (@(posedge clk) disable iff (!rst_n)
      entry_i |=> !ie_o);

   assert_clear_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i && !reti_i) |=> !ie_o);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
   parameter int unsigned PC_W     = 12,
   parameter int unsigned N_EXT    = 3,
   parameter int unsigned N_INT    = 10,
   parameter int unsigned VEC_STEP = 1,
   parameter int unsigned VEC_BASE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             instr_done_i,
   input  logic [PC_W-1:0]  pc_i,
   input  logic [N_EXT-1:0] ext_req_i,
   input  logic [N_INT-1:0] int_req_i,
   input  logic             reti_i,
   input  logic             ie_set_i,
   input  logic             ie_clr_i,
   output logic             redirect_o,
   output logic [PC_W-1:0]  target_o,
   output logic             save_o,
   output logic [PC_W-1:0]  save_pc_o,
   output logic [N_EXT-1:0] ack_ext_o,
   output logic [N_INT-1:0] ack_int_o,
   output logic             ie_o
);

   localparam int unsigned N_SRC = N_EXT + N_INT;
   localparam int unsigned IW    = irq_pkg::idx_bits(N_SRC);
   localparam longint unsigned SPAN =
      longint'(VEC_BASE) + longint'(N_SRC) * longint'(VEC_STEP);

   if (N_EXT < 1 || N_INT < 1) begin : g_bad_groups
      $error("irq_entry_seq: both source groups need at least one line");
   end
   if (SPAN > (longint'(1) << PC_W)) begin : g_bad_span
      $error("irq_entry_seq: vector table exceeds program counter range");
   end

   // External lines occupy the low slots, internal lines follow.
   logic [N_SRC-1:0] pending;
   logic [N_SRC-1:0] grant;
   logic [IW-1:0]    slot;
   logic             any_pending;
   logic [PC_W-1:0]  vec_addr;
   logic             take;

   assign pending = {int_req_i, ext_req_i};

   irq_pick #(.N(N_SRC)) u_pick (
      .req_i   (pending),
      .any_o   (any_pending),
      .grant_o (grant),
      .idx_o   (slot)
   );

   irq_vec_map #(
      .IW       (IW),
      .PC_W     (PC_W),
      .VEC_STEP (VEC_STEP),
      .VEC_BASE (VEC_BASE),
      .N_SLOTS  (N_SRC)
   ) u_map (
      .slot_i (slot),
      .addr_o (vec_addr)
   );

   assign take = instr_done_i & ie_o & any_pending;

   irq_ie_ctl u_ie (
      .clk     (clk),
      .rst_n   (rst_n),
      .entry_i (take),
      .reti_i  (reti_i),
      .set_i   (ie_set_i),
      .clr_i   (ie_clr_i),
      .ie_o    (ie_o)
   );

   logic             redirect_q;
   logic [PC_W-1:0]  target_q;
   logic [PC_W-1:0]  save_pc_q;
   logic [N_SRC-1:0] ack_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         redirect_q <= 1'b0;
         target_q   <= '0;
         save_pc_q  <= '0;
         ack_q      <= '0;
      end else begin
         redirect_q <= take;
         ack_q      <= take ? grant : '0;
         if (take) begin
            target_q  <= vec_addr;
            save_pc_q <= pc_i;
         end
      end
   end

   assign redirect_o = redirect_q;
   assign save_o     = redirect_q;
   assign target_o   = target_q;
   assign save_pc_o  = save_pc_q;
   assign ack_ext_o  = ack_q[N_EXT-1:0];
   assign ack_int_o  = ack_q[N_SRC-1:N_EXT];

   assert_boundary_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> $past(instr_done_i && ie_o));

   assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |=> !redirect_o);

   assert_ie_low_on_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> !ie_o);

   assert_save_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> (save_o && save_pc_o == $past(pc_i)));

   assert_ack_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> ($countones({ack_int_o, ack_ext_o}) == 1));

   assert_no_stray_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !redirect_o |-> ({ack_int_o, ack_ext_o} == '0));

   assert_masked_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ie_o |=> !redirect_o);

endmodule

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/1ps
module irq_entry_seq_test;

   localparam int PC_W = 12;
   localparam int NE   = 3;
   localparam int NI   = 10;
   localparam int NS   = NE + NI;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            instr_done = 1'b0;
   logic [PC_W-1:0] pc = '0;
   logic [NE-1:0]   ext_req = '0;
   logic [NI-1:0]   int_req = '0;
   logic            reti = 1'b0, ie_set = 1'b0, ie_clr = 1'b0;
   logic            redirect, save, ie;
   logic [PC_W-1:0] target, save_pc;
   logic [NE-1:0]   ack_ext;
   logic [NI-1:0]   ack_int;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;   // 125 MHz

   irq_entry_seq #(.PC_W(PC_W), .N_EXT(NE), .N_INT(NI), .VEC_STEP(1), .VEC_BASE(0)) uut (
      .clk(clk), .rst_n(rst_n), .instr_done_i(instr_done), .pc_i(pc),
      .ext_req_i(ext_req), .int_req_i(int_req), .reti_i(reti),
      .ie_set_i(ie_set), .ie_clr_i(ie_clr), .redirect_o(redirect),
      .target_o(target), .save_o(save), .save_pc_o(save_pc),
      .ack_ext_o(ack_ext), .ack_int_o(ack_int), .ie_o(ie)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // raise the enable flag through the software strobe
   task automatic enable();
      ie_set = 1'b1; step(); ie_set = 1'b0;
   endtask

   task automatic drive_req(input logic [NS-1:0] r);
      ext_req = r[NE-1:0];
      int_req = r[NS-1:NE];
   endtask

   // accept one entry with the given requests, check the redirect cycle
   task automatic entry(input logic [NS-1:0] r, input int win, input logic [PC_W-1:0] p);
      logic [NS-1:0] exp_ack;
      enable();
      drive_req(r); pc = p; instr_done = 1'b1;
      step();
      instr_done = 1'b0; drive_req('0);
      exp_ack = NS'(1) << win;
      chk(redirect === 1'b1, "R2", redirect, 1);
      chk(save === 1'b1 && save_pc === p, "R3", save_pc, p);
      chk(target === PC_W'(win), "R5", target, win);
      chk({ack_int, ack_ext} === exp_ack, "R6/R7", {ack_int, ack_ext}, exp_ack);
      chk(ie === 1'b0, "R4", ie, 0);
      step();
      chk(redirect === 1'b0 && {ack_int, ack_ext} === '0, "R7", {ack_int, ack_ext}, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (3) step();
      // R1: reset state
      chk(ie === 1'b0, "R1", ie, 0);
      chk(redirect === 1'b0 && save === 1'b0, "R1", redirect, 0);
      chk({ack_int, ack_ext} === '0, "R1", {ack_int, ack_ext}, 0);
      rst_n = 1'b1;
      step();

      // R9: requests with enable off are ignored
      drive_req('1); instr_done = 1'b1;
      repeat (4) begin
         step();
         chk(redirect === 1'b0 && save === 1'b0 && {ack_int, ack_ext} === '0,
             "R9", redirect, 0);
      end
      instr_done = 1'b0; drive_req('0);

      // R2: no boundary means no entry
      enable();
      drive_req(NS'(1) << 5);
      repeat (4) begin
         step();
         chk(redirect === 1'b0, "R2", redirect, 0);
      end
      chk(ie === 1'b1, "R2", ie, 1);
      drive_req('0);
      ie_clr = 1'b1; step(); ie_clr = 1'b0;
      chk(ie === 1'b0, "R8", ie, 0);

      // R5: each single source
      for (int s = 0; s < NS; s++) entry(NS'(1) << s, s, PC_W'(12'h100 + s * 7));

      // R6: every pair of sources
      for (int a = 0; a < NS; a++)
         for (int b = 0; b < NS; b++)
            entry((NS'(1) << a) | (NS'(1) << b), (a < b) ? a : b, PC_W'(a * 16 + b));

      // R6: all pending, slot 0 wins; all internal pending, slot NE wins
      entry('1, 0, 12'hABC);
      entry({NI'('1), NE'(0)}, NE, 12'h7FF);

      // R4: held requests and boundaries after entry cause no second entry
      enable();
      drive_req(NS'(1) << 4); instr_done = 1'b1; pc = 12'h222;
      step();
      chk(redirect === 1'b1, "R4", redirect, 1);
      repeat (3) begin
         step();
         chk(redirect === 1'b0 && ie === 1'b0, "R4", redirect, 0);
      end
      // R8: return strobe re-enables, then the held request is taken again
      instr_done = 1'b0;
      reti = 1'b1; step(); reti = 1'b0;
      chk(ie === 1'b1, "R8", ie, 1);
      instr_done = 1'b1; pc = 12'h333;
      step();
      instr_done = 1'b0; drive_req('0);
      chk(redirect === 1'b1 && target === 12'h004 && save_pc === 12'h333, "R8", target, 4);

      // R8: set and clear together, set wins; clear alone drops
      step();
      ie_set = 1'b1; ie_clr = 1'b1; step(); ie_set = 1'b0; ie_clr = 1'b0;
      chk(ie === 1'b1, "R8", ie, 1);
      ie_clr = 1'b1; step(); ie_clr = 1'b0;
      chk(ie === 1'b0, "R8", ie, 0);
      reti = 1'b1; ie_clr = 1'b1; step(); reti = 1'b0; ie_clr = 1'b0;
      chk(ie === 1'b1, "R8", ie, 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule